// File: doc/BRIEF.md
# Real-Time Clock Interrupt Status and Periodic Rate Unit

This block implements the interrupt side of a PC-style real-time clock. It keeps three sticky event flags: periodic, alarm and update-ended. It also keeps a control byte that holds one enable bit for each source, and a 4-bit rate code. The rate code divides a 32.768 kHz reference enable into a power-of-two periodic tick. The alarm-match and update-ended events arrive as single-cycle strobes from logic outside the block. The periodic event comes from the internal divider.

Software sees three byte-wide registers through a simple port. Register selection is on `regSel`. A write happens on `regWr`, and `rdData` is combinational from the selected register. A read strobe on the flag register clears every pending flag. A flag is recorded even when its source is disabled. The summary bit and the `irq` line report only the flags whose enables are set. A read issued right after an enable change therefore discards stale events.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset the control byte reads 0x00, the flag byte reads 0x00, the rate byte reads 0x06 and `irq` is low.
- R2: An alarm strobe sets flag bit 5 and an update strobe sets flag bit 4 on the next clock edge, whatever their enables are. A set flag stays set until the flag register is read.
- R3: Flag bit 7 and `irq` are high exactly when a pending flag in bits 6..4 has its enable set at the same bit position of the control byte. Both respond to changes in flags or enables with no further register delay.
- R4: A cycle with `regRd` high and `regSel`=2 clears the flags at the next edge, so `irq` falls in the following cycle.
- R5: A source event that arrives in the same cycle as a flag-register read is kept, and it is pending after that edge.
- R6: With rate code n from 1 to 15, the periodic flag (bit 6) is set once every 2^(n-1) reference enables. A free-running reference count that starts at zero at reset triggers on the enable where its low n-1 bits are all ones.
- R7: Rate code 0 produces no periodic events.
- R8: With the reset rate of 6 and a continuous reference enable, the first periodic flag appears on the 32nd reference enable.
- R9: Register map: address 0 is the rate byte (bits 3..0 kept, upper bits read 0), address 1 is the control byte (bits 6..4 kept, others read 0), address 2 is the flag byte, and address 3 reads 0. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refTick | input | 1 | One-cycle enable for each 32.768 kHz reference period |
| alarmHit | input | 1 | Alarm-match event strobe |
| updateDone | input | 1 | Update-ended event strobe |
| regSel | input | 2 | Register address |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe (clears flags when address is 2) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register |
| flagReg | output | 8 | Live flag byte: bit 7 summary, bits 6..4 periodic/alarm/update |
| irq | output | 1 | Active-high interrupt request |

## Verification
A corrupted flag bit shows on `flagReg` in the cycle after the bad edge. When the matching enable is set, it also shows on `irq` in that same cycle. A divider that slips its count shows up as a periodic flag that arrives one or more reference enables early or late. The rate-15 run lets such a slip build up over 16384 enables. A reference model of every register is compared at all three outputs after each edge, so any divergence is reported within one cycle of when it first becomes visible.

// File: rtl/rtc_irq_pkg.sv
`timescale 1ns/1ps
package rtc_irq_pkg;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 8;
  localparam logic [ADDR_W-1:0] SEL_RATE = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] SEL_FLAG = 2'd2;
  localparam logic [DATA_W-1:0] RATE_MASK = 8'h0F;
  localparam logic [DATA_W-1:0] CTRL_MASK = 8'h70;
  localparam logic [DATA_W-1:0] RATE_RESET = 8'h06;

  typedef struct packed {
    logic ctlWr;
    logic rateWr;
    logic flagRd;
  } regStrobe_t;
endpackage

// File: rtl/rtc_irq_ctrl.sv
`timescale 1ns/1ps
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] regSel,
  input  logic              regWr,
  input  logic              regRd,
  output regStrobe_t        stb
);
  always_comb begin
    stb.ctlWr  = regWr && (regSel == SEL_CTRL);
    stb.rateWr = regWr && (regSel == SEL_RATE);
    stb.flagRd = regRd && (regSel == SEL_FLAG);
  end
endmodule

// File: rtl/rtc_rate_div.sv
`timescale 1ns/1ps
module rtc_rate_div #(
  parameter int DIV_W  = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [RATE_W-1:0] rateCode,
  output logic              periodicTick
);
  logic [DIV_W-1:0] refCount;
  logic [DIV_W-1:0] lowMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refCount <= '0;
    else if (refTick) refCount <= refCount + 1'b1;
  end

  // bits below (rate-1) must all be ones for a tick
  always_comb begin
    for (int i = 0; i < DIV_W; i++)
      lowMask[i] = (i < (int'(rateCode) - 1));
  end

  assign periodicTick = refTick && (rateCode != '0) && (&(refCount | ~lowMask));
endmodule

// File: rtl/rtc_irq_datapath.sv
`timescale 1ns/1ps
module rtc_irq_datapath
  import rtc_irq_pkg::*;
#(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  input  logic [ADDR_W-1:0] regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              periodicTick,
  input  logic              alarmHit,
  input  logic              updateDone,
  output logic [RATE_W-1:0] rateCode,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] flagReg,
  output logic              irq
);
  logic [DATA_W-1:0] ctrlByte;
  logic [DATA_W-1:0] rateByte;
  logic [2:0]        srcFlag;   // {periodic, alarm, update}
  logic [2:0]        srcEvent;
  logic              summary;

  assign srcEvent = {periodicTick, alarmHit, updateDone};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlByte <= '0;
      rateByte <= RATE_RESET;
      srcFlag  <= '0;
    end else begin
      if (stb.ctlWr)  ctrlByte <= wrData & CTRL_MASK;
      if (stb.rateWr) rateByte <= wrData & RATE_MASK;
      srcFlag <= (stb.flagRd ? 3'b000 : srcFlag) | srcEvent;
    end
  end

  assign summary  = |(srcFlag & ctrlByte[6:4]);
  assign flagReg  = {summary, srcFlag, 4'b0000};
  assign irq      = summary;
  assign rateCode = rateByte[RATE_W-1:0];

  always_comb begin
    case (regSel)
      SEL_RATE: rdData = rateByte;
      SEL_CTRL: rdData = ctrlByte;
      SEL_FLAG: rdData = flagReg;
      default:  rdData = '0;
    endcase
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (|srcFlag) && !stb.flagRd |=> ((srcFlag & $past(srcFlag)) == $past(srcFlag))); // R2
  AST_READ_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    stb.flagRd && !(|srcEvent) |=> (srcFlag == 3'b000)); // R4
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    alarmHit |=> srcFlag[1]); // R5
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte[6:4] == 3'b000) |-> !irq); // R3
  AST_RATE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (rateByte == 8'h00) |-> !periodicTick); // R7
endmodule

// File: rtl/rtc_irq_unit.sv
`timescale 1ns/1ps
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              alarmHit,
  input  logic              updateDone,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] flagReg,
  output logic              irq
);
  regStrobe_t        stb;
  logic [RATE_W-1:0] rateCode;
  logic              periodicTick;

  rtc_irq_ctrl u_ctrl (
    .regSel(regSel), .regWr(regWr), .regRd(regRd), .stb(stb)
  );

  rtc_rate_div #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_div (
    .clk(clk), .rstN(rstN), .refTick(refTick),
    .rateCode(rateCode), .periodicTick(periodicTick)
  );

  rtc_irq_datapath #(.RATE_W(RATE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regSel(regSel), .wrData(wrData),
    .periodicTick(periodicTick), .alarmHit(alarmHit), .updateDone(updateDone),
    .rateCode(rateCode), .rdData(rdData), .flagReg(flagReg), .irq(irq)
  );
endmodule

// File: tb/rtc_irq_unit_test.sv
`timescale 1ns/1ps
module rtc_irq_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b0, alarmHit = 1'b0, updateDone = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData, flagReg;
  logic       irq;

  int tests = 0, fails = 0;
  string phase = "R1";

  // reference model state
  logic [2:0] mCtrl = 3'b000;
  logic [3:0] mRate = 4'd6;
  logic [2:0] mFlag = 3'b000;
  int         mCount = 0;

  always #2 clk = ~clk;

  rtc_irq_unit uut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .alarmHit(alarmHit),
    .updateDone(updateDone), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .wrData(wrData), .rdData(rdData), .flagReg(flagReg), .irq(irq)
  );

  function automatic logic [7:0] expFlag();
    return {|(mFlag & mCtrl), mFlag, 4'b0000};
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return {4'b0000, mRate};
      2'd1: return {1'b0, mCtrl, 4'b0000};
      2'd2: return expFlag();
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic rt, input logic ah, input logic ud, input logic [1:0] a,
                     input logic wr, input logic rd, input logic [7:0] wd);
    logic tick;
    int   mask;
    logic [2:0] nFlag;
    refTick = rt; alarmHit = ah; updateDone = ud;
    regSel = a; regWr = wr; regRd = rd; wrData = wd;
    mask = (mRate == 0) ? 0 : ((1 << (mRate - 1)) - 1);
    tick = rt && (mRate != 0) && ((mCount & mask) == mask);
    nFlag = ((rd && a == 2'd2) ? 3'b000 : mFlag) | {tick, ah, ud};
    @(posedge clk);
    #1;
    mFlag = nFlag;
    if (rt) mCount = (mCount + 1) % 32768;
    if (wr && a == 2'd1) mCtrl = wd[6:4];
    if (wr && a == 2'd0) mRate = wd[3:0];
    chk(phase, "flagReg", flagReg, expFlag());
    chk(phase, "irq", irq, expFlag() >> 7);
    chk(phase, "rdData", rdData, expRead(a));
  endtask

  task automatic idle(input int n, input logic rt);
    for (int i = 0; i < n; i++) cyc(rt, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int firstPf;
    #9 rstN = 1'b1;
    // R1 reset state
    #2;
    chk("R1", "flagReg", flagReg, 8'h00);
    chk("R1", "irq", irq, 0);
    cyc(0,0,0,2'd0,0,0,8'h00); chk("R1", "rate", rdData, 8'h06);
    cyc(0,0,0,2'd1,0,0,8'h00); chk("R1", "ctrl", rdData, 8'h00);

    // R9 register map and masking
    phase = "R9";
    cyc(0,0,0,2'd1,1,0,8'hFF); chk("R9", "ctrl mask", rdData, 8'h70);
    cyc(0,0,0,2'd1,1,0,8'h00);
    cyc(0,0,0,2'd0,1,0,8'hF3); chk("R9", "rate mask", rdData, 8'h03);
    cyc(0,0,0,2'd0,1,0,8'h06);
    cyc(0,0,0,2'd2,1,0,8'hFF); chk("R9", "flag write ignored", flagReg, 8'h00);
    cyc(0,0,0,2'd3,1,0,8'hFF); chk("R9", "addr3", rdData, 8'h00);
    cyc(0,0,0,2'd0,0,0,8'h00); chk("R9", "rate unchanged", rdData, 8'h06);

    // R8 default rate, continuous reference
    phase = "R8";
    firstPf = -1;
    for (int i = 1; i <= 70; i++) begin
      cyc(1,0,0,2'd2,0,0,8'h00);
      if (firstPf < 0 && flagReg[6]) firstPf = i;
    end
    chk("R8", "first periodic at ref enable", firstPf, 32 - (mCount - 70) + 0);
    cyc(0,0,0,2'd2,0,1,8'h00);

    // R2 flags latch while disabled
    phase = "R2";
    cyc(0,1,0,2'd2,0,0,8'h00); chk("R2", "alarm flag", flagReg, 8'h20);
    chk("R2", "irq masked", irq, 0);
    cyc(0,0,1,2'd2,0,0,8'h00); chk("R2", "update flag", flagReg, 8'h30);
    idle(5, 1'b0); chk("R2", "sticky", flagReg, 8'h30);

    // R3 enabling a pending source raises summary and irq
    phase = "R3";
    cyc(0,0,0,2'd1,1,0,8'h20); chk("R3", "irq on AIE", irq, 1);
    chk("R3", "summary", flagReg, 8'hB0);
    cyc(0,0,0,2'd1,1,0,8'h40); chk("R3", "irq with only PIE", irq, 0);
    cyc(0,0,0,2'd1,1,0,8'h10); chk("R3", "irq with UIE", irq, 1);

    // R4 read clears
    phase = "R4";
    cyc(0,0,0,2'd2,0,1,8'h00); chk("R4", "cleared", flagReg, 8'h00);
    chk("R4", "irq fell", irq, 0);

    // R5 event coincident with read wins
    phase = "R5";
    cyc(0,1,0,2'd2,0,0,8'h00);
    cyc(0,0,1,2'd2,0,1,8'h00); chk("R5", "update kept", flagReg, 8'h90);
    chk("R5", "irq", irq, 1);
    cyc(0,0,0,2'd2,0,1,8'h00);

    // R6 various rates, irregular reference enables
    phase = "R6";
    cyc(0,0,0,2'd1,1,0,8'h70);
    for (int r = 1; r <= 5; r++) begin
      cyc(0,0,0,2'd0,1,0,8'(r));
      for (int i = 0; i < 120; i++)
        cyc(1'($urandom_range(0,1)), 1'($urandom_range(0,20) == 0), 1'b0,
            2'd2, 1'b0, ($urandom_range(0,9) == 0), 8'h00);
    end
    cyc(0,0,0,2'd0,1,0,8'h0F);
    cyc(0,0,0,2'd2,0,1,8'h00);
    idle(33000, 1'b1);

    // R7 rate zero
    phase = "R7";
    cyc(0,0,0,2'd0,1,0,8'h00);
    cyc(0,0,0,2'd2,0,1,8'h00);
    idle(3000, 1'b1);
    chk("R7", "no periodic", flagReg[6], 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule